// File: doc/BRIEF.md
# Fracturable Lookup-Table Logic Element

This block is one programmable logic cell. It holds a 64-bit truth-table mask and a 2-bit mode in a single configuration shift chain. Once the chain is loaded and armed, two outputs are evaluated combinationally from eight routed input pins. The mask is stored as four 16-bit table slices. A fixed multiplexer network chooses the slice for each output, and the mode decides how the input pins form each output's table address.

There are three working modes. In wide mode the whole mask is one 6-input function on `outA`, and `outB` stays low. In split mode the mask is cut into two 32-bit halves, giving two 5-input functions that share two pins and so use eight distinct pins in total. In twin mode both outputs read the same 64-bit mask, use four common pins, and each takes its own two upper pins.

Configuration bits enter MSB-first through a serial port. The bit leaving the top of the chain is visible on `cfgOut`, so shifting in new contents reads the old contents back. The outputs are held at 0 until an arm pulse follows the last shift.

Top module: `frac_lut_cell`

## Requirements
- R1: After reset `outA`, `outB` and `cfgOut` are 0, and the outputs stay 0 for any pin values until the cell is configured and armed.
- R2: Each cycle with `cfgEn` high shifts `cfgData` into bit 0 of a 66-bit chain. Chain bits 65:64 are the mode and bits 63:0 are the mask, so a load sends mode bit 1 first and mask bit 0 last. `cfgOut` always shows chain bit 65, so a later 66-bit shift returns the loaded bits in the order they were sent.
- R3: A cycle with `cfgDone` high and `cfgEn` low arms the cell from the next cycle on. Any cycle with `cfgEn` high disarms it, and outputs are 0 while disarmed.
- R4: Mode 0 (wide): `outA` = mask[pins[5:0]] and `outB` = 0.
- R5: Mode 1 (split): `outA` = mask[{0, pins[4:0]}] and `outB` = mask[{1, pins[7:5], pins[1:0]}]. Pins 1:0 are shared by both functions.
- R6: Mode 2 (twin): `outA` = mask[pins[5:0]] and `outB` = mask[{pins[7:6], pins[3:0]}], both read from the same mask.
- R7: Mode 3 is unused, and both outputs are 0 in it.
- R8: A wide-mode mask with bit i set exactly when i[1:0] = 3 (0x8888_8888_8888_8888) makes `outA` the AND of pins 0 and 1.
- R9: In wide mode, pins 7:6 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgData | input | 1 | Serial configuration bit |
| cfgDone | input | 1 | Arm pulse after loading |
| cfgOut | output | 1 | Top bit of the configuration chain (readback) |
| pins | input | 8 | Routed logic inputs |
| outA | output | 1 | First function output |
| outB | output | 1 | Second function output |

## Verification
The hardest case to reach is the second output in split and twin modes. Its address is built from pins that the first output partly ignores, so a wrong pin-to-address wiring stays hidden unless the mask is asymmetric and the pins are swept widely. The bench loads distinct pseudo-random masks, walks all 256 pin values in every mode, and compares both outputs with a reference model written from the address rules. Readback is exercised by loading a second configuration while the first one's bits are captured from `cfgOut`.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE  = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_TWIN  = 2'd2,
    MODE_OFF   = 2'd3
  } lutMode_t;

  typedef struct packed {
    logic shift;
    logic live;
  } cfgStrobe_t;

endpackage

// File: rtl/frac_lut_ctrl.sv
module frac_lut_ctrl
  import frac_lut_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgEn,
  input  logic       cfgDone,
  output cfgStrobe_t stb
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (cfgEn)   armed <= 1'b0;
    else if (cfgDone) armed <= 1'b1;
  end

  always_comb begin
    stb.shift = cfgEn;
    stb.live  = armed;
  end

  // R3
  shift_disarms_chk: assert property (@(posedge clk) disable iff (rst)
    cfgEn |=> !stb.live);

  // R3
  done_arms_chk: assert property (@(posedge clk) disable iff (rst)
    (cfgDone && !cfgEn) |=> stb.live);

endmodule

// File: rtl/frac_lut_datapath.sv
module frac_lut_datapath
  import frac_lut_pkg::*;
#(
  parameter int LUT_K   = 6,
  parameter int SPLIT_M = 2,
  parameter int SLICE_IN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  cfgStrobe_t               stb,
  input  logic                     cfgData,
  input  logic [LUT_K+SPLIT_M-1:0] pins,
  output logic                     cfgOut,
  output logic                     outA,
  output logic                     outB
);

  localparam int PIN_COUNT  = LUT_K + SPLIT_M;
  localparam int MASK_BITS  = 1 << LUT_K;
  localparam int CHAIN_LEN  = MASK_BITS + 2;
  localparam int SLICE_BITS = 1 << SLICE_IN;
  localparam int SLICES     = MASK_BITS / SLICE_BITS;
  localparam int SEL_W      = LUT_K - SLICE_IN;
  localparam int SPLIT_SH   = LUT_K - 2 - SPLIT_M;   // pins shared in split mode
  localparam int SPLIT_OWN  = LUT_K - 1 - SPLIT_SH;  // pins private to outB in split mode
  localparam int TWIN_SH    = LUT_K - SPLIT_M;       // pins shared in twin mode

  logic [CHAIN_LEN-1:0] chain;
  logic [MASK_BITS-1:0] maskBits;
  lutMode_t             mode;

  always_ff @(posedge clk) begin
    if (rst)            chain <= '0;
    else if (stb.shift) chain <= {chain[CHAIN_LEN-2:0], cfgData};
  end

  assign maskBits = chain[MASK_BITS-1:0];
  assign mode     = lutMode_t'(chain[CHAIN_LEN-1:CHAIN_LEN-2]);
  assign cfgOut   = chain[CHAIN_LEN-1];

  // Input steering: each mode forms the two table addresses
  logic [LUT_K-1:0] addrA, addrB;
  logic             enA, enB;

  always_comb begin
    addrA = pins[LUT_K-1:0];
    addrB = '0;
    enA   = 1'b0;
    enB   = 1'b0;
    unique case (mode)
      MODE_WIDE: begin
        enA = 1'b1;
      end
      MODE_SPLIT: begin
        addrA = {1'b0, pins[LUT_K-2:0]};
        addrB = {1'b1, pins[PIN_COUNT-1 -: SPLIT_OWN], pins[SPLIT_SH-1:0]};
        enA   = 1'b1;
        enB   = 1'b1;
      end
      MODE_TWIN: begin
        addrB = {pins[PIN_COUNT-1 -: SPLIT_M], pins[TWIN_SH-1:0]};
        enA   = 1'b1;
        enB   = 1'b1;
      end
      default: begin
        enA = 1'b0;
        enB = 1'b0;
      end
    endcase
  end

  // Table slices with two read ports each
  logic [SLICES-1:0] sliceA, sliceB;

  for (genvar s = 0; s < SLICES; s++) begin : gSlice
    logic [SLICE_BITS-1:0] sliceMask;
    assign sliceMask = maskBits[s*SLICE_BITS +: SLICE_BITS];
    assign sliceA[s] = sliceMask[addrA[SLICE_IN-1:0]];
    assign sliceB[s] = sliceMask[addrB[SLICE_IN-1:0]];
  end

  // Mux network across slices
  logic rawA, rawB;
  logic [SEL_W-1:0] selA, selB;

  assign selA = addrA[LUT_K-1:SLICE_IN];
  assign selB = addrB[LUT_K-1:SLICE_IN];
  assign rawA = sliceA[selA];
  assign rawB = sliceB[selB];

  assign outA = stb.live & enA & rawA;
  assign outB = stb.live & enB & rawB;

  // R2
  shift_path_chk: assert property (@(posedge clk) disable iff (rst)
    stb.shift |=> (cfgOut == $past(chain[CHAIN_LEN-2])));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.shift |=> $stable(chain));

  // R4
  wide_b_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_WIDE) |-> !outB);

  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |-> (!outA && !outB));

  // R3
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.live |-> (!outA && !outB));

endmodule

// File: rtl/frac_lut_cell.sv
module frac_lut_cell
  import frac_lut_pkg::*;
#(
  parameter int LUT_K   = 6,
  parameter int SPLIT_M = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgEn,
  input  logic                     cfgData,
  input  logic                     cfgDone,
  output logic                     cfgOut,
  input  logic [LUT_K+SPLIT_M-1:0] pins,
  output logic                     outA,
  output logic                     outB
);

  cfgStrobe_t stb;

  frac_lut_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .cfgEn   (cfgEn),
    .cfgDone (cfgDone),
    .stb     (stb)
  );

  frac_lut_datapath #(
    .LUT_K   (LUT_K),
    .SPLIT_M (SPLIT_M)
  ) uPath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .cfgData (cfgData),
    .pins    (pins),
    .cfgOut  (cfgOut),
    .outA    (outA),
    .outB    (outB)
  );

endmodule

// File: tb/frac_lut_cell_test.sv
`timescale 1ns/1ps
module frac_lut_cell_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfgEn = 1'b0;
  logic       cfgData = 1'b0;
  logic       cfgDone = 1'b0;
  logic [7:0] pins = '0;
  logic       cfgOut, outA, outB;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  frac_lut_cell uut (
    .clk(clk), .rst(rst), .cfgEn(cfgEn), .cfgData(cfgData), .cfgDone(cfgDone),
    .cfgOut(cfgOut), .pins(pins), .outA(outA), .outB(outB)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // Reference model written from the address rules
  function automatic logic refA(input logic [1:0] md, input logic [63:0] mk, input logic [7:0] p);
    case (md)
      2'd0, 2'd2: refA = mk[p[5:0]];
      2'd1:       refA = mk[{1'b0, p[4:0]}];
      default:    refA = 1'b0;
    endcase
  endfunction

  function automatic logic refB(input logic [1:0] md, input logic [63:0] mk, input logic [7:0] p);
    case (md)
      2'd1:    refB = mk[{1'b1, p[7:5], p[1:0]}];
      2'd2:    refB = mk[{p[7:6], p[3:0]}];
      default: refB = 1'b0;
    endcase
  endfunction

  task automatic shiftIn(input logic [65:0] word);
    for (int i = 65; i >= 0; i--) begin
      @(negedge clk);
      cfgEn = 1'b1;
      cfgData = word[i];
    end
    @(negedge clk);
    cfgEn = 1'b0;
    cfgData = 1'b0;
  endtask

  task automatic arm();
    cfgDone = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
  endtask

  task automatic load(input logic [1:0] md, input logic [63:0] mk);
    shiftIn({md, mk});
    arm();
  endtask

  task automatic sweep(input string req, input logic [1:0] md, input logic [63:0] mk);
    for (int v = 0; v < 256; v++) begin
      pins = v[7:0];
      #1;
      check(req, $sformatf("outA pins=%02h", v), outA, refA(md, mk, v[7:0]));
      check(req, $sformatf("outB pins=%02h", v), outB, refB(md, mk, v[7:0]));
    end
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "cfgOut after reset", cfgOut, 1'b0);
    for (int v = 0; v < 256; v += 37) begin
      pins = v[7:0];
      #1;
      check("R1", "outA after reset", outA, 1'b0);
      check("R1", "outB after reset", outB, 1'b0);
    end
  endtask

  task automatic testArming();
    logic [63:0] mk = 64'hFFFF_FFFF_FFFF_FFFF;
    shiftIn({2'd0, mk});
    pins = 8'h15;
    #1;
    check("R3", "outA before arm", outA, 1'b0);
    arm();
    #1;
    check("R3", "outA after arm", outA, 1'b1);
    @(negedge clk);
    cfgEn = 1'b1;
    cfgData = 1'b1;
    @(negedge clk);
    cfgEn = 1'b0;
    #1;
    check("R3", "outA after one shift", outA, 1'b0);
    cfgDone = 1'b1;
    cfgEn = 1'b1;
    @(negedge clk);
    cfgDone = 1'b0;
    cfgEn = 1'b0;
    #1;
    check("R3", "done with shift does not arm", outA, 1'b0);
  endtask

  task automatic testWide();
    logic [63:0] mk = 64'hC3A5_1E7B_9064_D28F;
    load(2'd0, mk);
    sweep("R4", 2'd0, mk);
    for (int lo = 0; lo < 64; lo += 9) begin
      for (int hi = 0; hi < 4; hi++) begin
        pins = {hi[1:0], lo[5:0]};
        #1;
        check("R9", "outA ignores top pins", outA, mk[lo[5:0]]);
        check("R9", "outB stays low", outB, 1'b0);
      end
    end
  endtask

  task automatic testAnd();
    logic [63:0] mk = 64'h8888_8888_8888_8888;
    load(2'd0, mk);
    for (int v = 0; v < 4; v++) begin
      pins = {6'b101101, v[1:0]};
      #1;
      check("R8", "AND of pins 1:0", outA, v[0] & v[1]);
    end
  endtask

  task automatic testSplit();
    logic [63:0] mk = 64'h5A0F_3C96_E1D2_7B48;
    load(2'd1, mk);
    sweep("R5", 2'd1, mk);
  endtask

  task automatic testTwin();
    logic [63:0] mk = 64'h2F81_C6B3_947E_0DA5;
    load(2'd2, mk);
    sweep("R6", 2'd2, mk);
  endtask

  task automatic testOff();
    logic [63:0] mk = 64'hFFFF_FFFF_FFFF_FFFF;
    load(2'd3, mk);
    sweep("R7", 2'd3, mk);
  endtask

  task automatic testReadback();
    logic [65:0] first  = {2'b10, 64'h9B3E_0476_C1AF_52D8};
    logic [65:0] second = {2'b01, 64'h1234_5678_9ABC_DEF0};
    logic [65:0] seen;
    shiftIn(first);
    for (int i = 65; i >= 0; i--) begin
      @(negedge clk);
      seen[i] = cfgOut;
      cfgEn = 1'b1;
      cfgData = second[i];
    end
    @(negedge clk);
    cfgEn = 1'b0;
    for (int i = 65; i >= 0; i -= 5)
      check("R2", $sformatf("readback bit %0d", i), seen[i], first[i]);
    check("R2", "readback whole word", (seen == first), 1'b1);
    check("R2", "cfgOut shows new top bit", cfgOut, second[65]);
    arm();
    sweep("R2", 2'd1, second[63:0]);
  endtask

  initial begin
    testReset();
    testArming();
    testWide();
    testAnd();
    testSplit();
    testTwin();
    testOff();
    testReadback();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule